// File: doc/BRIEF.md
# Packet Capture Halt Controller

This block decides, cycle by cycle, whether an incoming transport packet is passed on to the capture path. It has two regimes. In continuous mode every packet that begins while the block is enabled is captured, and software is not involved. In handshake mode each captured packet raises a completion flag and a one-cycle interrupt. Software must clear the flag before the packet after next is allowed in.

In handshake mode one extra packet is tolerated after the flag rises. Software has that whole packet to clear the flag. If the flag is still set when that packet ends, the block halts. A halt always falls on a packet boundary. Once halted, the block ignores packet starts until the flag is cleared. A packet already in flight when capture resumes is skipped whole. A single-shot option removes the tolerated packet, so the block halts after every packet. The number of tolerated packets is a parameter, `GRACE_PKTS`, with a default of 1.

The controller is a five-state machine, with the state register and the output logic in separate processes. The states are:

- ST_OFF: disabled.
- ST_ARMED: enabled and waiting for a packet start.
- ST_SKIP: enabled, but letting an in-flight packet pass uncaptured.
- ST_CAPT: capturing.
- ST_HALT: held until software clears the flag.

The transitions are:

- OFF→ARMED: the enable is high and no packet is in flight.
- OFF→SKIP: the enable is high and a packet is in flight.
- ARMED→CAPT: a start strobe arrives.
- SKIP→ARMED: an end strobe arrives.
- CAPT→ARMED: an end strobe arrives and no halt is due.
- CAPT→HALT: an end strobe arrives and a halt is due.
- HALT→ARMED: the flag is cleared and no packet is in flight.
- HALT→SKIP: the flag is cleared and a packet is in flight.
- Any state→OFF: the enable is low.

Top module: `pcap_halt_ctrl`

## Requirements
- R1: While `cap_en` is 0, `cap_gate` is 0, and packet ends do not set `done_flag` or pulse `done_irq`. Dropping `cap_en` during a capture lowers `cap_gate` in that same cycle.
- R2: With `cont_mode`=0, the end strobe of a captured packet sets `done_flag`. The flag is visible from the next cycle. `done_irq` is high for exactly that one cycle, and this happens for every captured packet.
- R3: With `cont_mode`=1, packets are captured back to back. `done_flag` and `done_irq` are left unchanged.
- R4: With `cont_mode`=0 and `frame_mode`=0, a captured packet that ends while `done_flag` is still set moves the block to halt. The packet after it is not captured.
- R5: A `flag_clr` pulse at any time during the tolerated packet keeps capture running, including in the same cycle as that packet's end strobe. In that same-cycle case the flag is set again by the end.
- R6: `cap_gate` is 1 from the start-strobe cycle through the end-strobe cycle of each captured packet. A halt never truncates a packet. While halted, start strobes are ignored and `done_flag` stays 1.
- R7: `flag_clr` while halted resumes capture at the next packet start. A packet whose start came at or before the clearing cycle is skipped entirely.
- R8: With `cont_mode`=0 and `frame_mode`=1, the block halts after every captured packet.
- R9: Dropping `cap_en` returns the machine to ST_OFF and zeroes the tolerated-packet count. `done_flag` is kept. On re-enable, a packet already in flight is skipped.
- R10: Reset (`rst_n`=0, asynchronous) forces ST_OFF. It also makes `cap_gate`, `done_flag` and `done_irq` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture enable |
| cont_mode | input | 1 | 1 = continuous capture, 0 = handshake capture |
| frame_mode | input | 1 | 1 = halt after every packet in handshake mode |
| pkt_start | input | 1 | One-cycle strobe on the first cycle of a packet |
| pkt_end | input | 1 | One-cycle strobe on the last cycle of a packet |
| flag_clr | input | 1 | Software clear of the completion flag |
| cap_gate | output | 1 | High on each cycle of a captured packet |
| done_flag | output | 1 | Packet-complete status flag |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
A wrong state shows up at `cap_gate` no later than the next start strobe. A halt state reached too early drops the gate on the tolerated packet. A missed halt leaves the gate high on the packet that should have been refused. A stale in-flight record shows as a gated packet whose start was never seen. Errors in the flag or the tolerated-packet count appear one cycle after an end strobe, as a missing or extra `done_irq` pulse or a wrong `done_flag` level. The stimulus therefore places `flag_clr` before, inside and on the last cycle of the tolerated packet.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ARMED = 3'd1,
        ST_SKIP  = 3'd2,
        ST_CAPT  = 3'd3,
        ST_HALT  = 3'd4
    } pcap_state_e;

    // Width of a counter that must hold values 0..max_val
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/pcap_pkt_track.sv
module pcap_pkt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_start,
    input  logic pkt_end,
    output logic busy
);

    logic in_pkt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_pkt_q <= 1'b0;
        end else if (pkt_start) begin
            in_pkt_q <= 1'b1;
        end else if (pkt_end) begin
            in_pkt_q <= 1'b0;
        end
    end

    // A packet is under way if it starts now or began earlier and is not ending now
    always_comb begin
        busy = pkt_start || (in_pkt_q && !pkt_end);
    end

    // R7
    track_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && !pkt_start) |=> !in_pkt_q);

endmodule

// File: rtl/pcap_grace.sv
module pcap_grace #(
    parameter int GRACE_PKTS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic cont_mode,
    input  logic frame_mode,
    input  logic end_cap,
    input  logic flag_clr,
    output logic halt_req,
    output logic done_flag,
    output logic done_irq
);
    import pcap_pkg::*;

    localparam int CW = cnt_width(GRACE_PKTS);
    localparam logic [CW:0] LIM_MAX = (CW+1)'(GRACE_PKTS);

    logic [CW-1:0] grace_cnt_q;
    logic          flag_q;
    logic          irq_q;
    logic          flag_live;
    logic          hs_end;
    logic [CW:0]   lim;
    logic [CW:0]   cnt_inc;

    always_comb begin
        hs_end    = end_cap && !cont_mode;
        flag_live = flag_q && !flag_clr;
        lim       = frame_mode ? '0 : LIM_MAX;
        cnt_inc   = {1'b0, grace_cnt_q} + 1'b1;
        if (!hs_end) begin
            halt_req = 1'b0;
        end else if (lim == '0) begin
            halt_req = 1'b1;
        end else if (!flag_live) begin
            halt_req = 1'b0;
        end else begin
            halt_req = (cnt_inc >= lim);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grace_cnt_q <= '0;
        end else if (!cap_en) begin
            grace_cnt_q <= '0;
        end else if (hs_end) begin
            if (!flag_live || halt_req) begin
                grace_cnt_q <= '0;
            end else begin
                grace_cnt_q <= cnt_inc[CW-1:0];
            end
        end else if (flag_clr) begin
            grace_cnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= hs_end;
            if (hs_end) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        done_flag = flag_q;
        done_irq  = irq_q;
    end

    // R2
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> done_flag);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, grace_cnt_q} <= LIM_MAX));

    // R9
    cnt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> (grace_cnt_q == '0));

endmodule

// File: rtl/pcap_fsm.sv
module pcap_fsm
    import pcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_en,
    input  logic        pkt_start,
    input  logic        pkt_end,
    input  logic        busy,
    input  logic        halt_req,
    input  logic        flag_clr,
    output pcap_state_e state_q,
    output logic        cap_gate,
    output logic        end_cap
);

    pcap_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = busy ? ST_SKIP : ST_ARMED;
            ST_ARMED: if (pkt_start) state_d = ST_CAPT;
            ST_SKIP:  if (pkt_end)   state_d = ST_ARMED;
            ST_CAPT:  if (pkt_end)   state_d = halt_req ? ST_HALT : ST_ARMED;
            ST_HALT:  if (flag_clr)  state_d = busy ? ST_SKIP : ST_ARMED;
            default:  state_d = ST_OFF;
        endcase
        if (!cap_en) begin
            state_d = ST_OFF;
        end
    end

    // Outputs
    always_comb begin
        cap_gate = cap_en && (((state_q == ST_ARMED) && pkt_start) || (state_q == ST_CAPT));
        end_cap  = cap_en && (state_q == ST_CAPT) && pkt_end;
    end

    // R1
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> (state_q == ST_OFF));

    // R6
    capt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT && cap_en && !pkt_end) |=> (state_q == ST_CAPT));

    // R7
    skip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !cap_gate);

endmodule

// File: rtl/pcap_halt_ctrl.sv
module pcap_halt_ctrl #(
    parameter int GRACE_PKTS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic cont_mode,
    input  logic frame_mode,
    input  logic pkt_start,
    input  logic pkt_end,
    input  logic flag_clr,
    output logic cap_gate,
    output logic done_flag,
    output logic done_irq
);
    import pcap_pkg::*;

    pcap_state_e fsm_state;
    logic        busy;
    logic        halt_req;
    logic        end_cap;

    pcap_pkt_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .pkt_end   (pkt_end),
        .busy      (busy)
    );

    pcap_grace #(.GRACE_PKTS(GRACE_PKTS)) u_grace (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .cont_mode  (cont_mode),
        .frame_mode (frame_mode),
        .end_cap    (end_cap),
        .flag_clr   (flag_clr),
        .halt_req   (halt_req),
        .done_flag  (done_flag),
        .done_irq   (done_irq)
    );

    pcap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .pkt_start (pkt_start),
        .pkt_end   (pkt_end),
        .busy      (busy),
        .halt_req  (halt_req),
        .flag_clr  (flag_clr),
        .state_q   (fsm_state),
        .cap_gate  (cap_gate),
        .end_cap   (end_cap)
    );

    // R6
    halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HALT) |-> done_flag);

    // R3
    cont_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_gate && pkt_end && cont_mode) |=> !done_irq);

    // R8
    frame_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_gate && pkt_end && !cont_mode && frame_mode) |=> (fsm_state == ST_HALT));

endmodule

// File: tb/tb_pcap_halt_ctrl.sv
module tb_pcap_halt_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_en = 1'b0, cont_mode = 1'b0, frame_mode = 1'b0;
    logic pkt_start = 1'b0, pkt_end = 1'b0, flag_clr = 1'b0;
    logic cap_gate, done_flag, done_irq;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pcap_halt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cont_mode(cont_mode),
        .frame_mode(frame_mode), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .flag_clr(flag_clr), .cap_gate(cap_gate), .done_flag(done_flag),
        .done_irq(done_irq)
    );

    // Row: {en, cont, frame, start, end, clr, exp_gate, exp_flag_after, exp_irq_after}
    localparam int NV = 42;
    localparam bit [8:0] VEC [NV] = '{
        9'b100000_000, // 0  R10 enable from OFF
        9'b100100_100, // 1  R6 start gated
        9'b100000_100, // 2
        9'b100010_111, // 3  R2 flag + irq
        9'b100000_010, // 4
        9'b100100_110, // 5  R4 tolerated packet
        9'b100010_111, // 6  R4 halt at its end
        9'b100100_010, // 7  R6 start ignored while halted
        9'b100010_010, // 8
        9'b100100_010, // 9
        9'b100001_000, // 10 R7 clear mid-packet -> skip
        9'b100010_000, // 11 R7 skipped end
        9'b100100_100, // 12 R7 resumed
        9'b100001_100, // 13
        9'b100010_111, // 14 R2
        9'b100100_110, // 15
        9'b100001_100, // 16 R5 clear inside tolerated packet
        9'b100010_111, // 17 R5 no halt
        9'b100100_110, // 18
        9'b100011_111, // 19 R5 clear on end cycle
        9'b100100_110, // 20 R5 still captured
        9'b100010_111, // 21 R4 halt
        9'b100001_000, // 22 R7 clear while idle
        9'b110100_100, // 23 R3 continuous
        9'b110010_100, // 24 R3 no flag
        9'b110100_100, // 25
        9'b110010_100, // 26
        9'b110100_100, // 27
        9'b110010_100, // 28
        9'b101100_100, // 29 R8 single shot
        9'b101010_111, // 30 R8 halt
        9'b101100_010, // 31 R8 halted
        9'b101010_010, // 32
        9'b101001_000, // 33
        9'b100100_100, // 34 R1 capture begins
        9'b000000_000, // 35 R1 enable drop cuts gate
        9'b000010_000, // 36 R1 end while off: no flag
        9'b000100_000, // 37 R1 start while off
        9'b100000_000, // 38 R9 re-enable mid-packet -> skip
        9'b100010_000, // 39 R9 skipped end
        9'b100100_100, // 40
        9'b100010_111  // 41 R2
    };
    localparam int REQ [NV] = '{10,6,6,2,2,4,4,6,6,6,7,7,7,2,2,5,5,5,5,5,5,4,7,
                                3,3,3,3,3,3,8,8,8,8,8,1,1,1,1,9,9,9,2};

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic drive(input bit [5:0] in);
        {cap_en, cont_mode, frame_mode, pkt_start, pkt_end, flag_clr} = in;
    endtask

    // Drive at negedge, check gate before the edge, registered outputs after it
    task automatic step(input bit [8:0] v, input string tag);
        @(negedge clk);
        drive(v[8:3]);
        #2;
        check(tag, cap_gate, v[2], "cap_gate");
        @(posedge clk);
        #2;
        check(tag, done_flag, v[1], "done_flag");
        check(tag, done_irq, v[0], "done_irq");
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cap_en = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R10 reset values
        check("R10", cap_gate, 1'b0, "cap_gate in reset");
        check("R10", done_flag, 1'b0, "done_flag in reset");
        check("R10", done_irq, 1'b0, "done_irq in reset");
        @(negedge clk);
        rst_n = 1'b1;
        drive(6'b000000);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i], $sformatf("R%0d vec%0d", REQ[i], i));
        end

        // R9 enable drop keeps the flag; re-enable allows the tolerated packet rule again
        step(9'b000000_010, "R9 off keeps flag");
        step(9'b100000_010, "R9 re-enable");
        step(9'b100100_110, "R9 packet after re-enable");
        step(9'b100010_111, "R9 halt at end");
        step(9'b100100_010, "R9 halted start ignored");
        step(9'b100010_010, "R9 halted end");

        // R10 reset mid-run clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R10", done_flag, 1'b0, "done_flag after async reset");
        check("R10", cap_gate, 1'b0, "cap_gate after async reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(9'b100000_000, "R10 rearm after reset");
        step(9'b100100_100, "R10 capture after reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule